// File: doc/BRIEF.md
# DMA Transfer Pattern Sequencer

This block produces the byte-by-byte address stream for one channel of a DMA engine. The engine copies bytes out of a linear source memory into a small window of peripheral registers. A start pulse captures the channel settings: a control byte, a source start address, a destination base offset and a byte count. The block then alternates between one read request and one write request until the count runs out, and raises a one-cycle done flag when it finishes.

The control byte sets two things. The first is how the source address moves after each read: it can step up, step down or stay fixed. The second is one of several fixed destination patterns. These patterns fan consecutive bytes over one, two or four neighbouring peripheral registers, and some of them double back to the base. Both bus sides use a request/acknowledge handshake. A request stays raised, with its address and data held steady, until it is acknowledged, so the block waits without loss while the bus is busy.

The controller has four named states. IDLE waits for start. READ holds the read request. WRITE holds the write request. DONE lasts one cycle and drives the done flag. The transitions are:
- IDLE→READ on start.
- READ→WRITE on a read acknowledge.
- WRITE→READ on a write acknowledge while bytes remain.
- WRITE→DONE on the acknowledge of the final write.
- DONE→IDLE always.

Top module: `xfer_pattern_seq`

## Requirements
- R1: After reset, rd_req, wr_req, busy and done are all low, and no request is raised until start is pulsed.
- R2: Each byte is one read handshake followed by one write handshake. rd_req and wr_req are never high together, and wr_data equals the byte returned on rd_data in that byte's read.
- R3: Source stepping after each read depends on control bits. When ctrl_byte[3]=1 the address holds. When ctrl_byte[3]=0, it goes up by one if ctrl_byte[4]=0 and down by one if ctrl_byte[4]=1. Arithmetic is modulo 2^ADDR_W.
- R4: Pattern codes ctrl_byte[2:0]=000 and 010 write every byte to dst_base.
- R5: Pattern code 001 writes bytes alternately to dst_base and dst_base+1, starting at dst_base.
- R6: Pattern code 011 writes to offsets 0,0,1,1 from dst_base, repeating every four bytes.
- R7: Pattern code 100 writes to offsets 0,1,2,3 from dst_base and then returns to offset 0. Destination arithmetic wraps modulo 2^DST_W.
- R8: Pattern codes 101, 110 and 111 give exactly the destination sequences of 001, 011 and 100 respectively.
- R9: The block moves exactly byte_count bytes. A byte_count of zero means 2^COUNT_W bytes.
- R10: The transfer stops after the last write even when the pattern is part-way through. done is high for exactly one cycle, the cycle after the final write handshake.
- R11: While a request is not acknowledged, it stays high and its address (and write data) stay unchanged.
- R12: A start pulse while busy is high is ignored. The running transfer keeps its original settings.
- R13: ctrl_byte bits 7 to 5 have no effect on any address or data produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_byte | input | 8 | Channel control: [2:0] pattern, [3] source hold, [4] source down |
| src_start | input | ADDR_W | First source address |
| dst_base | input | DST_W | Destination base register offset |
| byte_count | input | COUNT_W | Number of bytes, zero meaning the full range |
| start | input | 1 | One-cycle pulse that begins a transfer when idle |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, rd_data valid with it |
| rd_data | input | 8 | Byte returned by the source |
| wr_req | output | 1 | Write request |
| wr_addr | output | DST_W | Destination register offset |
| wr_data | output | 8 | Byte to write |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | High from start until the end of the done cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle by the assertions:
- read and write requests never overlap;
- a read handshake is always followed by a write request;
- requests hold steady while unacknowledged;
- the one-step source movement is correct in each mode;
- the byte counter never underflows;
- done is a single-cycle pulse that follows the final write;
- settings stay put when start arrives mid-transfer.

Only the bench scenarios can show the complete destination sequences for each pattern code and alias, the zero-count full range, a stop part-way through a pattern, wrap-around of both addresses, and the blindness to the upper control bits.

// File: rtl/xps_pkg.sv
package xps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } xps_state_e;

    // Destination pattern families
    typedef enum logic [1:0] {
        PAT_FIXED,   // offset 0 always
        PAT_PAIR,    // 0,1,0,1
        PAT_DOUBLE,  // 0,0,1,1
        PAT_QUAD     // 0,1,2,3
    } xps_pat_e;

    typedef enum logic [1:0] {
        SRC_INC,
        SRC_DEC,
        SRC_HOLD
    } xps_src_e;

    typedef struct packed {
        xps_pat_e pat;
        xps_src_e smode;
    } xps_cfg_t;

    localparam int STEP_W = 2;  // position inside a four-write unit

endpackage

// File: rtl/xps_ctrl_decode.sv
module xps_ctrl_decode
    import xps_pkg::*;
(
    input  logic [4:0] ctrl,
    output xps_cfg_t   cfg
);

    always_comb begin
        unique case (ctrl[2:0])
            3'b000:  cfg.pat = PAT_FIXED;
            3'b001:  cfg.pat = PAT_PAIR;
            3'b010:  cfg.pat = PAT_FIXED;
            3'b011:  cfg.pat = PAT_DOUBLE;
            3'b100:  cfg.pat = PAT_QUAD;
            3'b101:  cfg.pat = PAT_PAIR;    // alias of 001
            3'b110:  cfg.pat = PAT_DOUBLE;  // alias of 011
            3'b111:  cfg.pat = PAT_QUAD;    // alias of 100
            default: cfg.pat = PAT_FIXED;
        endcase
    end

    always_comb begin
        if (ctrl[3])
            cfg.smode = SRC_HOLD;
        else if (ctrl[4])
            cfg.smode = SRC_DEC;
        else
            cfg.smode = SRC_INC;
    end

endmodule

// File: rtl/xps_dst_offset.sv
module xps_dst_offset
    import xps_pkg::*;
(
    input  xps_pat_e          pat,
    input  logic [STEP_W-1:0] step,
    output logic [1:0]        off
);

    always_comb begin
        unique case (pat)
            PAT_FIXED:  off = 2'd0;
            PAT_PAIR:   off = {1'b0, step[0]};
            PAT_DOUBLE: off = {1'b0, step[1]};
            PAT_QUAD:   off = step;
            default:    off = 2'd0;
        endcase
    end

endmodule

// File: rtl/xps_src_addr.sv
module xps_src_addr
    import xps_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    input  xps_src_e          smode,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        unique case (smode)
            SRC_INC:  addr_nx = addr_q + 1'b1;
            SRC_DEC:  addr_nx = addr_q - 1'b1;
            SRC_HOLD: addr_nx = addr_q;
            default:  addr_nx = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= start_addr;
        else if (step)
            addr_q <= addr_nx;
    end

    assign addr = addr_q;

    p_src_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && smode == SRC_INC) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
    p_src_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && smode == SRC_DEC) |=> addr_q == ADDR_W'($past(addr_q) - 1'b1));
    p_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && smode == SRC_HOLD) |=> $stable(addr_q));

endmodule

// File: rtl/xps_byte_counter.sv
module xps_byte_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] count_in,
    input  logic               dec,
    output logic               last
);

    localparam int REM_W = COUNT_W + 1;
    localparam logic [REM_W-1:0] FULL = REM_W'(1) << COUNT_W;

    logic [REM_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load)
            rem_q <= (count_in == '0) ? FULL : REM_W'(count_in);
        else if (dec)
            rem_q <= rem_q - 1'b1;
    end

    assign last = (rem_q == REM_W'(1));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> rem_q != '0);

endmodule

// File: rtl/xfer_pattern_seq.sv
module xfer_pattern_seq
    import xps_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DST_W   = 8,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         ctrl_byte,
    input  logic [ADDR_W-1:0]  src_start,
    input  logic [DST_W-1:0]   dst_base,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic               start,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_ack,
    input  logic [7:0]         rd_data,
    output logic               wr_req,
    output logic [DST_W-1:0]   wr_addr,
    output logic [7:0]         wr_data,
    input  logic               wr_ack,
    output logic               busy,
    output logic               done
);

    xps_state_e        state_q, state_nx;
    xps_cfg_t          cfg_dec, cfg_q;
    logic [DST_W-1:0]  base_q;
    logic [7:0]        data_q;
    logic [STEP_W-1:0] step_q;
    logic [1:0]        off;
    logic              last;
    logic              launch, rd_hs, wr_hs;
    logic [2:0]        unused_ctrl;

    assign unused_ctrl = ctrl_byte[7:5];

    xps_ctrl_decode u_dec (
        .ctrl (ctrl_byte[4:0]),
        .cfg  (cfg_dec)
    );

    assign launch = (state_q == ST_IDLE) && start;
    assign rd_hs  = rd_req && rd_ack;
    assign wr_hs  = wr_req && wr_ack;

    xps_src_addr #(.ADDR_W(ADDR_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .start_addr (src_start),
        .step       (rd_hs),
        .smode      (cfg_q.smode),
        .addr       (rd_addr)
    );

    xps_byte_counter #(.COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .count_in (byte_count),
        .dec      (wr_hs),
        .last     (last)
    );

    xps_dst_offset u_off (
        .pat  (cfg_q.pat),
        .step (step_q),
        .off  (off)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)  state_nx = ST_READ;
            ST_READ:  if (rd_ack) state_nx = ST_WRITE;
            ST_WRITE: if (wr_ack) state_nx = last ? ST_DONE : ST_READ;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_req = 1'b0;
        wr_req = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy   = 1'b0;
            ST_READ:  rd_req = 1'b1;
            ST_WRITE: wr_req = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  busy   = 1'b0;
        endcase
    end

    assign wr_addr = base_q + DST_W'(off);
    assign wr_data = data_q;

    // Per-transfer settings and byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '{pat: PAT_FIXED, smode: SRC_INC};
            base_q <= '0;
            data_q <= '0;
            step_q <= '0;
        end else begin
            if (launch) begin
                cfg_q  <= cfg_dec;
                base_q <= dst_base;
                step_q <= '0;
            end
            if (rd_hs)
                data_q <= rd_data;
            if (wr_hs)
                step_q <= step_q + 1'b1;
        end
    end

    p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hs |=> wr_req && wr_data == $past(rd_data));
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr));
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req && $stable(wr_addr) && $stable(wr_data));
    p_last_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hs && last) |=> done);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(base_q) && $stable(cfg_q));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req && !done);

endmodule

// File: tb/sim_xfer_pattern_seq.sv
`timescale 1ns/1ps
module sim_xfer_pattern_seq;

    localparam int ADDR_W  = 24;
    localparam int DST_W   = 8;
    localparam int COUNT_W = 10;
    localparam int LOGN    = 2048;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         ctrl_byte = '0;
    logic [ADDR_W-1:0]  src_start = '0;
    logic [DST_W-1:0]   dst_base = '0;
    logic [COUNT_W-1:0] byte_count = '0;
    logic               start = 1'b0;
    logic               rd_req, wr_req, busy, done;
    logic [ADDR_W-1:0]  rd_addr;
    logic [DST_W-1:0]   wr_addr;
    logic [7:0]         wr_data, rd_data;
    logic               rd_ack = 1'b0, wr_ack = 1'b0;

    int checks = 0, fails = 0;
    int nrd = 0, nwr = 0, stall_ctr = 0;
    bit stall_en = 1'b0;
    logic [ADDR_W-1:0] rd_log [LOGN];
    logic [DST_W-1:0]  wa_log [LOGN];
    logic [7:0]        wd_log [LOGN];

    always #2.5 clk = ~clk;

    xfer_pattern_seq #(.ADDR_W(ADDR_W), .DST_W(DST_W), .COUNT_W(COUNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .src_start(src_start),
        .dst_base(dst_base), .byte_count(byte_count), .start(start),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign rd_data = mem_byte(rd_addr);

    // Bus responder: decides acks at the falling edge and logs each handshake
    always @(negedge clk) begin
        bit go;
        stall_ctr = stall_ctr + 1;
        go = !stall_en || (stall_ctr % 3 == 0);
        rd_ack = rd_req && go;
        wr_ack = wr_req && go;
        if (rd_req && go) begin
            if (nrd < LOGN) rd_log[nrd] = rd_addr;
            nrd = nrd + 1;
        end
        if (wr_req && go) begin
            if (nwr < LOGN) begin
                wa_log[nwr] = wr_addr;
                wd_log[nwr] = wr_data;
            end
            nwr = nwr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_off(input logic [2:0] code, input int i);
        int k = i % 4;
        case (code)
            3'b001, 3'b101: return k % 2;
            3'b011, 3'b110: return k / 2;
            3'b100, 3'b111: return k;
            default:        return 0;
        endcase
    endfunction

    task automatic run_xfer(input logic [7:0] ctrl, input logic [ADDR_W-1:0] src,
                            input logic [DST_W-1:0] base, input logic [COUNT_W-1:0] cnt,
                            input bit stall, input bit poke, input string req);
        int n, t;
        bit bad_src, bad_dst, bad_dat;
        n = (cnt == 0) ? (1 << COUNT_W) : int'(cnt);
        @(negedge clk);
        ctrl_byte = ctrl; src_start = src; dst_base = base; byte_count = cnt;
        nrd = 0; nwr = 0; stall_en = stall;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            ctrl_byte = ~ctrl; src_start = ~src; dst_base = ~base; byte_count = 10'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t = t + 1;
        end
        chk(done, req, "done seen before timeout", done, 1);
        @(negedge clk);
        chk(!done && !busy, "R10", "done width one cycle then idle", {done, busy}, 0);
        chk(nrd == n, "R9", "read count", nrd, n);
        chk(nwr == n, "R9", "write count", nwr, n);
        bad_src = 0; bad_dst = 0; bad_dat = 0;
        for (int i = 0; i < n && i < LOGN; i++) begin
            logic [ADDR_W-1:0] es;
            logic [DST_W-1:0]  ed;
            if (ctrl[3])      es = src;
            else if (ctrl[4]) es = src - ADDR_W'(i);
            else              es = src + ADDR_W'(i);
            ed = base + DST_W'(exp_off(ctrl[2:0], i));
            if (!bad_src && rd_log[i] !== es) begin
                bad_src = 1;
                chk(0, "R3", $sformatf("source addr byte %0d", i), rd_log[i], es);
            end
            if (!bad_dst && wa_log[i] !== ed) begin
                bad_dst = 1;
                chk(0, req, $sformatf("dest offset byte %0d", i), wa_log[i], ed);
            end
            if (!bad_dat && wd_log[i] !== mem_byte(es)) begin
                bad_dat = 1;
                chk(0, "R2", $sformatf("write data byte %0d", i), wd_log[i], mem_byte(es));
            end
        end
        if (!bad_src) chk(1, "R3", "source sequence", 0, 0);
        if (!bad_dst) chk(1, req, "destination sequence", 0, 0);
        if (!bad_dat) chk(1, "R2", "data follows read", 0, 0);
        stall_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rd_req && !wr_req && !busy && !done, "R1", "reset outputs",
            {rd_req, wr_req, busy, done}, 0);
        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_req, "R1", "no request without start", {rd_req, wr_req}, 0);
    endtask

    task automatic t_fixed();
        run_xfer(8'h00, 24'h001000, 8'h18, 10'd5, 0, 0, "R4");
        run_xfer(8'h02, 24'h002000, 8'h22, 10'd4, 0, 0, "R4");
    endtask

    task automatic t_pair();
        run_xfer(8'h11, 24'h000003, 8'h40, 10'd7, 0, 0, "R5");  // down, wraps below zero
    endtask

    task automatic t_double();
        run_xfer(8'h0B, 24'h123456, 8'h04, 10'd9, 1, 0, "R6");  // source held, stalls
    endtask

    task automatic t_quad();
        run_xfer(8'h04, 24'hFFFFFE, 8'hFE, 10'd6, 0, 0, "R7");  // stops mid unit, wraps
    endtask

    task automatic t_alias();
        run_xfer(8'h05, 24'h000100, 8'h10, 10'd6, 0, 0, "R8");
        run_xfer(8'h06, 24'h000200, 8'h20, 10'd7, 0, 0, "R8");
        run_xfer(8'h07, 24'h000300, 8'h30, 10'd9, 0, 0, "R8");
    endtask

    task automatic t_upper_bits();
        run_xfer(8'hE4, 24'h004000, 8'h60, 10'd8, 0, 0, "R13");
        run_xfer(8'hB3, 24'h005000, 8'h70, 10'd5, 0, 0, "R13");
    endtask

    task automatic t_zero_count();
        run_xfer(8'h01, 24'h010000, 8'h80, 10'd0, 0, 0, "R9");
    endtask

    task automatic t_busy_start();
        run_xfer(8'h04, 24'h020000, 8'h90, 10'd10, 0, 1, "R12");
    endtask

    task automatic t_stall();
        run_xfer(8'h14, 24'h030010, 8'hA0, 10'd11, 1, 0, "R11");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_pair();
        t_double();
        t_quad();
        t_alias();
        t_upper_bits();
        t_zero_count();
        t_busy_start();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule